// File: doc/BRIEF.md
# Software-Managed Unified Translation Buffer

This block is a fully associative translation buffer that caches virtual-to-physical page mappings for one processor. A single array of entries serves both instruction-side and data-side translation, so both sides draw on the same set of mappings. Each entry records its own page size, from 1 KB up to 16 MB. Each entry also carries an 8-bit owner tag. The tag is compared with the current process identifier, or it marks the page as global.

Software owns the buffer completely. The block never picks a victim and never refills an entry on its own. An entry changes only when software writes it at an index that software chooses, which lets software keep critical mappings resident indefinitely. A combinational readback port lets software inspect any entry. A privileged special-register port holds the current process identifier. A lookup port takes a virtual address and, one clock later, returns a hit flag, the winning index, a multi-hit flag and the translated physical address.

Top module: `utlb_top`

## Requirements
- R1: While reset is asserted and after it is released, every entry reads back with valid low, the process identifier reads as zero, and lookups miss.
- R2: A write (`sw_we` high) stores the valid bit, size code, tag, virtual page number (address bits 31:10) and physical page number (address bits 31:10) into entry `sw_idx` at the clock edge. The readback port shows entry `sw_ridx` combinationally, and its contents change only through such writes.
- R3: Size code k (0 to 7) selects a page of 1 KB times 4^k. The low 10+2k address bits are left out of the compare and are copied unchanged from the virtual address into the physical address. The remaining high bits come from the entry's physical page number.
- R4: An entry matches only when it is valid, its page number equals the lookup address on the bits that R3 compares, and its tag equals the current process identifier or is zero (a global page).
- R5: When several entries match, the lowest-numbered one supplies the index and the address, and `lk_multi` goes high. With a single match, `lk_multi` stays low.
- R6: Results appear on the lookup outputs in the cycle after `lk_req` is sampled high. A miss, or a cycle with no request, gives hit, multi, index and address all zero.
- R7: A lookup in the same cycle as a write to a matching entry sees the contents from before the write.
- R8: The process-ID register sits at special-register address 945. A privileged write loads `spr_wdata[7:0]`. A privileged read returns the identifier in `spr_rdata[7:0]` with bits 31:8 zero.
- R9: A non-privileged read or write at address 945 raises `spr_err` in the same cycle, leaves the identifier unchanged and returns zero data. Accesses to any other address raise no error and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sw_we | input | 1 | Entry write strobe |
| sw_idx | input | 6 | Entry index to write |
| sw_wvalid | input | 1 | Valid bit to store |
| sw_wsize | input | 3 | Page size code to store |
| sw_wtag | input | 8 | Owner tag to store (0 = global) |
| sw_wvpn | input | 22 | Virtual page number to store |
| sw_wppn | input | 22 | Physical page number to store |
| sw_ridx | input | 6 | Entry index to read back |
| rb_valid | output | 1 | Readback valid bit |
| rb_size | output | 3 | Readback size code |
| rb_tag | output | 8 | Readback tag |
| rb_vpn | output | 22 | Readback virtual page number |
| rb_ppn | output | 22 | Readback physical page number |
| spr_wr | input | 1 | Special-register write strobe |
| spr_rd | input | 1 | Special-register read strobe |
| spr_priv | input | 1 | Access is privileged |
| spr_addr | input | 10 | Special-register address |
| spr_wdata | input | 32 | Special-register write data |
| spr_rdata | output | 32 | Special-register read data |
| spr_err | output | 1 | Privilege violation on the process-ID register |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Registered hit |
| lk_multi | output | 1 | Registered multi-hit flag |
| lk_idx | output | 6 | Registered winning index |
| lk_pa | output | 32 | Registered physical address |

## Verification
A software entry write and a lookup can fall in the same clock cycle, and the lookup may target the very entry being rewritten. The bench drives both in one cycle: it invalidates the lowest-numbered of several overlapping global 16 MB entries while a lookup aims at that entry. The scoreboard computes the expected result from its model before it applies the write, so it expects the old winner. It then expects the next lookup to fall to the next-lowest entry, with the multi-hit flag still raised.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int VA_W   = 32;
  localparam int MIN_SH = 10;
  localparam int PN_W   = VA_W - MIN_SH;
  localparam int SZ_W   = 3;
  localparam int TAG_W  = 8;
  localparam int SPR_AW = 10;
  localparam int SPR_DW = 32;
  localparam logic [SPR_AW-1:0] PID_ADDR = SPR_AW'(945);

  typedef struct packed {
    logic             valid;
    logic [SZ_W-1:0]  size;
    logic [TAG_W-1:0] tag;
    logic [PN_W-1:0]  vpn;
    logic [PN_W-1:0]  ppn;
  } tlbe_t;

  localparam int BODY_W = $bits(tlbe_t) - 1;

  // Ones on the page-number bits that take part in the compare.
  function automatic logic [PN_W-1:0] pn_mask(input logic [SZ_W-1:0] sz);
    logic [PN_W-1:0] m;
    m = '1;
    return m << {sz, 1'b0};
  endfunction
endpackage

// File: rtl/utlb_store.sv
module utlb_store
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  tlbe_t                wentry,
  input  logic [IDX_W-1:0]     ridx,
  output tlbe_t                rentry,
  output tlbe_t [ENTRIES-1:0]  ents
);
  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] vld_d;
  logic [ENTRIES-1:0] wsel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    logic [BODY_W-1:0] body_q;

    always_comb begin
      wsel[g]  = we && (widx == GI);
      vld_d[g] = wsel[g] ? wentry.valid : vld_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[g] <= 1'b0;
      else        vld_q[g] <= vld_d[g];
    end

    // Payload needs no reset: valid gates every use.
    always_ff @(posedge clk) begin
      if (wsel[g]) body_q <= wentry[BODY_W-1:0];
    end

    assign ents[g] = {vld_q[g], body_q};
  end

  assign rentry = ents[ridx];

  // R2: a write lands in the addressed entry by the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ents[$past(widx)] == $past(wentry)));
endmodule

// File: rtl/utlb_match.sv
module utlb_match
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  tlbe_t [ENTRIES-1:0] ents,
  input  logic [PN_W-1:0]     va_pn,
  input  logic [TAG_W-1:0]    pid,
  output logic [ENTRIES-1:0]  match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [PN_W-1:0] cmask;
    logic            pn_eq;
    logic            tag_ok;
    always_comb begin
      cmask    = pn_mask(ents[g].size);
      pn_eq    = ((ents[g].vpn ^ va_pn) & cmask) == '0;
      tag_ok   = (ents[g].tag == pid) || (ents[g].tag == '0);
      match[g] = ents[g].valid && pn_eq && tag_ok;
    end
  end
endmodule

// File: rtl/utlb_pick.sv
module utlb_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match,
  output logic               hit,
  output logic               multi,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
    hit   = |match;
    multi = (match & (match - ENTRIES'(1))) != '0;
  end
endmodule

// File: rtl/utlb_pid.sv
module utlb_pid
  import utlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic              priv,
  input  logic [SPR_AW-1:0] addr,
  input  logic [SPR_DW-1:0] wdata,
  output logic [SPR_DW-1:0] rdata,
  output logic              err,
  output logic [TAG_W-1:0]  pid
);
  logic             sel;
  logic             pid_en;
  logic [TAG_W-1:0] pid_d;
  logic [TAG_W-1:0] pid_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[SPR_DW-1:TAG_W];

  always_comb begin
    sel    = (addr == PID_ADDR);
    pid_en = wr && sel && priv;
    pid_d  = pid_en ? wdata[TAG_W-1:0] : pid_q;
    err    = (wr || rd) && sel && !priv;
    rdata  = (rd && sel && priv) ? {{(SPR_DW-TAG_W){1'b0}}, pid_q} : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pid_q <= '0;
    else        pid_q <= pid_d;
  end

  assign pid = pid_q;

  // R9: a rejected access leaves the identifier alone
  p_pid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(pid_q));
  // R8: a privileged write loads the low data byte
  p_pid_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && priv && addr == PID_ADDR) |=> (pid_q == $past(wdata[TAG_W-1:0])));
endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              sw_wvalid,
  input  logic [SZ_W-1:0]   sw_wsize,
  input  logic [TAG_W-1:0]  sw_wtag,
  input  logic [PN_W-1:0]   sw_wvpn,
  input  logic [PN_W-1:0]   sw_wppn,
  input  logic [IDX_W-1:0]  sw_ridx,
  output logic              rb_valid,
  output logic [SZ_W-1:0]   rb_size,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [PN_W-1:0]   rb_vpn,
  output logic [PN_W-1:0]   rb_ppn,
  input  logic              spr_wr,
  input  logic              spr_rd,
  input  logic              spr_priv,
  input  logic [SPR_AW-1:0] spr_addr,
  input  logic [SPR_DW-1:0] spr_wdata,
  output logic [SPR_DW-1:0] spr_rdata,
  output logic              spr_err,
  input  logic              lk_req,
  input  logic [VA_W-1:0]   lk_va,
  output logic              lk_hit,
  output logic              lk_multi,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [VA_W-1:0]   lk_pa
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rs_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  tlbe_t                wentry;
  tlbe_t                rentry;
  tlbe_t [ENTRIES-1:0]  ents;
  logic  [TAG_W-1:0]    pid;
  logic  [ENTRIES-1:0]  match;
  logic                 hit_c;
  logic                 multi_c;
  logic  [IDX_W-1:0]    idx_c;

  assign wentry = '{valid: sw_wvalid, size: sw_wsize, tag: sw_wtag,
                    vpn: sw_wvpn, ppn: sw_wppn};

  utlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n_s), .we(sw_we), .widx(sw_idx), .wentry(wentry),
    .ridx(sw_ridx), .rentry(rentry), .ents(ents)
  );

  assign rb_valid = rentry.valid;
  assign rb_size  = rentry.size;
  assign rb_tag   = rentry.tag;
  assign rb_vpn   = rentry.vpn;
  assign rb_ppn   = rentry.ppn;

  utlb_pid u_pid (
    .clk(clk), .rst_n(rst_n_s), .wr(spr_wr), .rd(spr_rd), .priv(spr_priv),
    .addr(spr_addr), .wdata(spr_wdata), .rdata(spr_rdata), .err(spr_err),
    .pid(pid)
  );

  utlb_match #(.ENTRIES(ENTRIES)) u_match (
    .ents(ents), .va_pn(lk_va[VA_W-1:MIN_SH]), .pid(pid), .match(match)
  );

  utlb_pick #(.ENTRIES(ENTRIES)) u_pick (
    .match(match), .hit(hit_c), .multi(multi_c), .idx(idx_c)
  );

  // Next-state for the lookup result register.
  tlbe_t            sel_e;
  logic [PN_W-1:0]  sel_m;
  logic             res_hit_d, res_multi_d;
  logic [IDX_W-1:0] res_idx_d;
  logic [VA_W-1:0]  res_pa_d;
  logic             take;

  always_comb begin
    sel_e = ents[idx_c];
    sel_m = pn_mask(sel_e.size);
    take  = lk_req && hit_c;
    res_hit_d   = take;
    res_multi_d = take && multi_c;
    res_idx_d   = take ? idx_c : '0;
    res_pa_d    = take ? {(sel_e.ppn & sel_m) | (lk_va[VA_W-1:MIN_SH] & ~sel_m),
                          lk_va[MIN_SH-1:0]} : '0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lk_hit   <= 1'b0;
      lk_multi <= 1'b0;
      lk_idx   <= '0;
      lk_pa    <= '0;
    end else begin
      lk_hit   <= res_hit_d;
      lk_multi <= res_multi_d;
      lk_idx   <= res_idx_d;
      lk_pa    <= res_pa_d;
    end
  end

  // R6: misses and idle cycles present all-zero results
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lk_hit |-> (lk_pa == '0 && lk_idx == '0 && !lk_multi));
  // R6: no request, no hit one cycle later
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !lk_req |=> !lk_hit);
  // R5: multi-hit only accompanies a hit
  p_multi_hit_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    lk_multi |-> lk_hit);
  // R5: chosen index matches and no lower index matches
  p_first_match_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    hit_c |-> (match[idx_c] &&
               ((match & ~({ENTRIES{1'b1}} << idx_c)) == '0)));
  // R3: page offset bits pass straight through
  p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (lk_req && hit_c) |=> (lk_pa[MIN_SH-1:0] == $past(lk_va[MIN_SH-1:0])));
endmodule

// File: tb/sim_utlb_top.sv
`timescale 1ns/1ps
module sim_utlb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        sw_we, sw_wvalid;
  logic [5:0]  sw_idx, sw_ridx;
  logic [2:0]  sw_wsize;
  logic [7:0]  sw_wtag;
  logic [21:0] sw_wvpn, sw_wppn;
  logic        rb_valid;
  logic [2:0]  rb_size;
  logic [7:0]  rb_tag;
  logic [21:0] rb_vpn, rb_ppn;
  logic        spr_wr, spr_rd, spr_priv;
  logic [9:0]  spr_addr;
  logic [31:0] spr_wdata, spr_rdata;
  logic        spr_err;
  logic        lk_req;
  logic [31:0] lk_va;
  logic        lk_hit, lk_multi;
  logic [5:0]  lk_idx;
  logic [31:0] lk_pa;

  utlb_top u0 (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench model of the buffer, built from the requirements.
  bit          m_v[64];
  int unsigned m_sz[64];
  int unsigned m_tag[64];
  int unsigned m_vpn[64];
  int unsigned m_ppn[64];
  int unsigned m_pid = 0;

  typedef struct {
    logic        hit;
    logic        multi;
    logic [5:0]  idx;
    logic [31:0] pa;
    string       req;
  } item_t;
  item_t sb[$];

  function automatic item_t predict(input logic [31:0] va, input string req);
    item_t r;
    int    n;
    r.hit = 0; r.multi = 0; r.idx = 0; r.pa = 0; r.req = req;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      int unsigned off;
      off = 10 + 2 * m_sz[i];
      if (m_v[i] && ((va >> off) == ((m_vpn[i] << 10) >> off)) &&
          (m_tag[i] == m_pid || m_tag[i] == 0)) begin
        if (n == 0) begin
          r.hit = 1;
          r.idx = 6'(i);
          r.pa  = (((m_ppn[i] << 10) >> off) << off) | (va & ((32'd1 << off) - 1));
        end
        n++;
      end
    end
    r.multi = (n > 1);
    return r;
  endfunction

  task automatic model_write(input int i, input bit v, input int unsigned sz,
                             input int unsigned tag, input int unsigned vpn,
                             input int unsigned ppn);
    m_v[i] = v; m_sz[i] = sz; m_tag[i] = tag; m_vpn[i] = vpn; m_ppn[i] = ppn;
  endtask

  // Write and lookup may share one cycle (R7).
  task automatic drive(input bit do_wr, input int i, input bit v,
                       input int unsigned sz, input int unsigned tag,
                       input int unsigned vpn, input int unsigned ppn,
                       input bit do_lk, input logic [31:0] va, input string req);
    @(negedge clk);
    if (do_lk) begin
      sb.push_back(predict(va, req));
      lk_req = 1; lk_va = va;
    end
    if (do_wr) begin
      model_write(i, v, sz, tag, vpn, ppn);
      sw_we = 1; sw_idx = 6'(i); sw_wvalid = v; sw_wsize = 3'(sz);
      sw_wtag = 8'(tag); sw_wvpn = 22'(vpn); sw_wppn = 22'(ppn);
    end
    @(negedge clk);
    lk_req = 0; sw_we = 0;
  endtask

  task automatic wr_ent(input int i, input bit v, input int unsigned sz,
                        input int unsigned tag, input int unsigned vpn,
                        input int unsigned ppn);
    drive(1, i, v, sz, tag, vpn, ppn, 0, 32'd0, "");
  endtask

  task automatic look(input logic [31:0] va, input string req);
    drive(0, 0, 0, 0, 0, 0, 0, 1, va, req);
  endtask

  task automatic spr(input bit wr, input bit rd, input bit priv, input logic [9:0] a,
                     input logic [31:0] d, output logic [31:0] rdat, output logic err);
    @(negedge clk);
    spr_wr = wr; spr_rd = rd; spr_priv = priv; spr_addr = a; spr_wdata = d;
    #1;
    rdat = spr_rdata; err = spr_err;
    if (wr && priv && a == 10'd945) m_pid = d[7:0];
    @(negedge clk);
    spr_wr = 0; spr_rd = 0;
  endtask

  task automatic rb_check(input int i, input string req);
    sw_ridx = 6'(i);
    #1;
    chk(rb_valid == m_v[i] && (!m_v[i] ||
        (rb_size == 3'(m_sz[i]) && rb_tag == 8'(m_tag[i]) &&
         rb_vpn == 22'(m_vpn[i]) && rb_ppn == 22'(m_ppn[i]))), req, "readback",
        {rb_valid, rb_size, rb_tag, rb_vpn, rb_ppn},
        {m_v[i], 3'(m_sz[i]), 8'(m_tag[i]), 22'(m_vpn[i]), 22'(m_ppn[i])});
  endtask

  // Scoreboard monitor.
  bit pend = 0;
  bit live = 0;
  always @(posedge clk) pend <= lk_req;

  always @(negedge clk) begin
    if (live) begin
      if (pend) begin
        if (sb.size() == 0) begin
          chk(0, "R6", "unexpected result", {lk_hit, lk_idx, lk_pa}, 0);
        end else begin
          item_t e;
          e = sb.pop_front();
          chk(lk_hit == e.hit && lk_multi == e.multi && lk_idx == e.idx && lk_pa == e.pa,
              e.req, "lookup", {lk_hit, lk_multi, lk_idx, lk_pa},
              {e.hit, e.multi, e.idx, e.pa});
        end
      end else begin
        chk(!lk_hit && !lk_multi && lk_idx == 0 && lk_pa == 0, "R6", "idle outputs",
            {lk_hit, lk_multi, lk_idx, lk_pa}, 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R6", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    rst_n = 0; sw_we = 0; sw_idx = 0; sw_wvalid = 0; sw_wsize = 0; sw_wtag = 0;
    sw_wvpn = 0; sw_wppn = 0; sw_ridx = 0; spr_wr = 0; spr_rd = 0; spr_priv = 0;
    spr_addr = 0; spr_wdata = 0; lk_req = 0; lk_va = 0;
    for (int i = 0; i < 64; i++) model_write(i, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(lk_hit == 0 && lk_pa == 0, "R1", "outputs in reset", {lk_hit, lk_pa}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1: reset state
    rb_check(0, "R1");
    rb_check(63, "R1");
    spr(0, 1, 1, 10'd945, 0, rd, er);
    chk(rd == 0 && !er, "R1", "pid after reset", {er, rd}, 0);
    look(32'h0000_0000, "R1");

    // R8: privileged write and read
    spr(1, 0, 1, 10'd945, 32'hABCD_EF5A, rd, er);
    chk(!er, "R8", "priv write err", er, 0);
    spr(0, 1, 1, 10'd945, 0, rd, er);
    chk(rd == 32'h0000_005A && !er, "R8", "priv read", {er, rd}, 32'h5A);

    // R9: non-privileged accesses rejected
    spr(1, 0, 0, 10'd945, 32'h77, rd, er);
    chk(er == 1, "R9", "unpriv write err", er, 1);
    spr(0, 1, 0, 10'd945, 0, rd, er);
    chk(er == 1 && rd == 0, "R9", "unpriv read", {er, rd}, {1'b1, 32'h0});
    spr(1, 0, 1, 10'd944, 32'h33, rd, er);
    chk(!er, "R9", "other address err", er, 0);
    spr(0, 1, 1, 10'd945, 0, rd, er);
    chk(rd == 32'h5A, "R9", "pid unchanged", rd, 32'h5A);

    spr(1, 0, 1, 10'd945, 32'h5, rd, er);

    // R2: writes and readback
    wr_ent(3, 1, 0, 5, 22'h12345, 22'h00ABC);
    wr_ent(10, 1, 7, 0, 32'h4A00_0000 >> 10, 22'h3C0000);
    wr_ent(20, 1, 2, 9, 22'h00800, 22'h01000);
    rb_check(3, "R2");
    rb_check(10, "R2");
    rb_check(20, "R2");

    // R3/R4: hits on small and large pages
    look({22'h12345, 10'h1FF}, "R4");
    look(32'h4A12_3456, "R3");
    look(32'h0020_0010, "R4");
    spr(1, 0, 1, 10'd945, 32'h9, rd, er);
    look(32'h0020_3FFC, "R3");
    look(32'h4A98_7654, "R4");
    look({22'h12345, 10'h0}, "R4");

    // R5: overlapping global entries, lowest index wins
    wr_ent(40, 1, 7, 0, 32'h4A00_0000 >> 10, 22'h040000);
    look(32'h4A00_0001, "R5");
    wr_ent(5, 1, 7, 0, 32'h4A00_0000 >> 10, 22'h080000);
    look(32'h4AFF_FFFF, "R5");

    // R7: write and lookup in the same cycle see old contents
    drive(1, 5, 0, 7, 0, 32'h4A00_0000 >> 10, 22'h080000, 1, 32'h4A00_0100, "R7");
    look(32'h4A00_0100, "R7");

    // R6: plain miss
    look(32'h0000_0000, "R6");
    look(32'hFFFF_FFFF, "R6");

    // R3/R4: sweep of size codes
    for (int k = 0; k < 8; k++) begin
      wr_ent(48 + k, 1, k, 9, (32'h1000_0000 * k) >> 10, 22'h3FFFFF);
      look(32'h1000_0000 * k + 32'h0001_2345 * k + 32'h3, "R3");
    end
    for (int k = 0; k < 12; k++) look(32'h0123_4567 * k, "R4");

    rb_check(3, "R2");
    rb_check(5, "R2");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule